// File: doc/BRIEF.md
# Register-Map Slave for a Lightweight Memory-Mapped Bus

This block is an AXI4-Lite slave that holds a small bank of 32-bit registers and serves single-beat reads and writes on the five standard channels. Each incoming address is decoded against the implemented registers. A legal write updates the selected register one byte lane at a time, as the write strobes allow. A legal read returns the stored word. An access outside the map finishes with a slave-error response and changes nothing.

The write address and the write data are captured independently, in either order or in the same cycle. The write takes effect only when both halves are held. The write response follows one cycle later. Each direction allows one outstanding transaction. A response stays posted, unchanged, until the master accepts it. The block has no inputs besides the bus, a clock and an active-low synchronous reset.

Top module: `axil_regslave`

## Requirements
- R1: While reset is low at a clock edge, every register clears to zero, both response-valid outputs go low, and all three address and data ready outputs are high after reset is released.
- R2: A write to a legal address with all four strobe bits set stores the whole 32-bit word, and a later read of that address returns it.
- R3: A legal write changes only the byte lanes whose strobe bit is set (strobe bit n covers data bits 8n+7 down to 8n). A write with strobe 4'b0000 leaves the register unchanged.
- R4: A write to an illegal address completes with write response 2'b10 (slave error) and leaves every register unchanged.
- R5: A read from an illegal address completes with read response 2'b10 (slave error) and read data of zero.
- R6: The write completes correctly whether the address arrives first, the data arrives first, or both arrive in the same cycle.
- R7: The write-response valid rises exactly one clock cycle after the cycle in which both the address and the data are held, and never before both are held.
- R8: Once the write-response valid is high, it stays high with the response unchanged until the response-ready input is sampled high. It then drops on that edge.
- R9: Once the read-data valid is high, it stays high with data and response unchanged until the read-ready input is sampled high. It then drops on that edge.
- R10: The map has eight independent registers at byte offsets 0x00, 0x04, ... 0x1C. Any other address, including a misaligned one (low two bits not zero) or one with high bits set, is illegal.
- R11: Every legal read and every legal write completes with response 2'b00 (OKAY). Only 2'b00 and 2'b10 are ever produced.
- R12: While a write response is pending, the write address and data ready outputs are low. While read data is pending, the read address ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| aw_addr | input | 32 | Write address |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address can be taken |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Per-byte write enables |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data can be taken |
| b_resp | output | 2 | Write response code |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Master accepts write response |
| ar_addr | input | 32 | Read address |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address can be taken |
| r_data | output | 32 | Read data |
| r_resp | output | 2 | Read response code |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Master accepts read data |

## Verification
Writes are driven with full strobes, sparse strobes (alternate lanes), the complementary lanes and an empty strobe. Reading each result back tells lane-accurate merging apart from whole-word overwrites. Each of the three arrival orders of address and data is used at least once, so a slave that assumes a fixed order stalls or commits stale data. Illegal addresses are tried just past the map, misaligned inside it, and with only the top bit set. Each is followed by a read of a neighbouring legal register, which shows that an error path neither writes nor aliases into the map.

// File: rtl/axil_rs_pkg.sv
package axil_rs_pkg;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOK   = 2'b01,
      RESP_SLVERR = 2'b10,
      RESP_DECERR = 2'b11
   } resp_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/axil_rs_decode.sv
module axil_rs_decode #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned LSB     = $clog2(DATA_W / 8),
   localparam int unsigned IDX_W   = axil_rs_pkg::idx_width(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned WORD_W = ADDR_W - LSB;
   localparam bit IS_POW2 = (NUM_REGS > 1) && ((NUM_REGS & (NUM_REGS - 1)) == 0);

   logic aligned;

   assign aligned = (addr[LSB-1:0] == '0);
   assign idx     = addr[LSB +: IDX_W];

   generate
      if (IS_POW2) begin : g_pow2
         // upper word bits above the index must all be zero
         assign hit = aligned && (addr[ADDR_W-1:LSB+IDX_W] == '0);
      end else begin : g_range
         logic [WORD_W-1:0] word_num;
         assign word_num = addr[ADDR_W-1:LSB];
         assign hit = aligned && (word_num < WORD_W'(NUM_REGS));
      end
   endgenerate

endmodule

// File: rtl/axil_rs_regfile.sv
module axil_rs_regfile #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned STRB_W  = DATA_W / 8,
   localparam int unsigned IDX_W   = axil_rs_pkg::idx_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [NUM_REGS*DATA_W-1:0] flat;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [DATA_W-1:0] word_q;
         logic              sel;

         assign sel = wr_en && (wr_idx == IDX_W'(r));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (sel) begin
               for (int l = 0; l < STRB_W; l++) begin
                  if (wr_strb[l]) word_q[l*8 +: 8] <= wr_data[l*8 +: 8];
               end
            end
         end

         assign flat[r*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rd_idx == IDX_W'(r)) rd_word = flat[r*DATA_W +: DATA_W];
      end
   end

   // storage may only move on a qualified (legal) commit
   assert_no_stray_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(flat));

   assert_empty_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_strb == '0)) |=> $stable(flat));

endmodule

// File: rtl/axil_rs_wr_chan.sv
module axil_rs_wr_chan
   import axil_rs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              w_valid,
   output logic              w_ready,
   output logic [1:0]        b_resp,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ADDR_W-1:0] held_addr,
   input  logic              addr_hit,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);

   logic aw_full, w_full, commit;

   assign aw_ready = !aw_full && !b_valid;
   assign w_ready  = !w_full && !b_valid;
   assign commit   = aw_full && w_full;
   assign wr_en    = commit && addr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_full   <= 1'b0;
         w_full    <= 1'b0;
         held_addr <= '0;
         wr_data   <= '0;
         wr_strb   <= '0;
         b_valid   <= 1'b0;
         b_resp    <= RESP_OKAY;
      end else begin
         if (aw_valid && aw_ready) begin
            aw_full   <= 1'b1;
            held_addr <= aw_addr;
         end
         if (w_valid && w_ready) begin
            w_full  <= 1'b1;
            wr_data <= w_data;
            wr_strb <= w_strb;
         end
         if (commit) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            b_valid <= 1'b1;
            b_resp  <= addr_hit ? RESP_OKAY : RESP_SLVERR;
         end else if (b_valid && b_ready) begin
            b_valid <= 1'b0;
         end
      end
   end

   assert_bresp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

   assert_bvalid_after_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_valid) |-> $past(aw_full && w_full));

   assert_no_commit_while_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !b_valid);

   assert_bresp_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid |-> (b_resp == RESP_OKAY || b_resp == RESP_SLVERR));

endmodule

// File: rtl/axil_rs_rd_chan.sv
module axil_rs_rd_chan
   import axil_rs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic              addr_hit,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_valid,
   input  logic              r_ready
);

   assign ar_ready = !r_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_data  <= '0;
         r_resp  <= RESP_OKAY;
      end else if (ar_valid && ar_ready) begin
         r_valid <= 1'b1;
         r_data  <= addr_hit ? rd_word : '0;
         r_resp  <= addr_hit ? RESP_OKAY : RESP_SLVERR;
      end else if (r_valid && r_ready) begin
         r_valid <= 1'b0;
      end
   end

   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)));

   assert_error_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_resp == RESP_SLVERR) |-> (r_data == '0));

   assert_one_read_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> !ar_ready);

endmodule

// File: rtl/axil_regslave.sv
module axil_regslave #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned STRB_W  = DATA_W / 8,
   localparam int unsigned IDX_W   = axil_rs_pkg::idx_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              w_valid,
   output logic              w_ready,
   output logic [1:0]        b_resp,
   output logic              b_valid,
   input  logic              b_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic              ar_valid,
   output logic              ar_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_valid,
   input  logic              r_ready
);

   localparam int unsigned LSB = $clog2(STRB_W);

   initial begin
      assert (DATA_W == 32 || DATA_W == 64)
         else $error("DATA_W must be 32 or 64");
      assert (NUM_REGS >= 1)
         else $error("NUM_REGS must be at least 1");
      assert (ADDR_W > LSB + IDX_W)
         else $error("ADDR_W too narrow for the register map");
   end

   logic [ADDR_W-1:0] wr_addr_q;
   logic              wr_hit, rd_hit, wr_en;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_word;
   logic [STRB_W-1:0] wr_strb;

   axil_rs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_wdec (
      .addr (wr_addr_q),
      .hit  (wr_hit),
      .idx  (wr_idx)
   );

   axil_rs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rdec (
      .addr (ar_addr),
      .hit  (rd_hit),
      .idx  (rd_idx)
   );

   axil_rs_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .aw_addr   (aw_addr),
      .aw_valid  (aw_valid),
      .aw_ready  (aw_ready),
      .w_data    (w_data),
      .w_strb    (w_strb),
      .w_valid   (w_valid),
      .w_ready   (w_ready),
      .b_resp    (b_resp),
      .b_valid   (b_valid),
      .b_ready   (b_ready),
      .held_addr (wr_addr_q),
      .addr_hit  (wr_hit),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_strb   (wr_strb)
   );

   axil_rs_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .wr_strb (wr_strb),
      .rd_idx  (rd_idx),
      .rd_word (rd_word)
   );

   axil_rs_rd_chan #(.DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ar_valid (ar_valid),
      .ar_ready (ar_ready),
      .addr_hit (rd_hit),
      .rd_word  (rd_word),
      .r_data   (r_data),
      .r_resp   (r_resp),
      .r_valid  (r_valid),
      .r_ready  (r_ready)
   );

   assert_rresp_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> (r_resp == 2'b00 || r_resp == 2'b10));

endmodule

// File: tb/axil_regslave_test.sv
`timescale 1ns/1ps
module axil_regslave_test;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [1:0]  resp;
      logic [31:0] rdata;
      logic [1:0]  mode;   // 0 together, 1 address first, 2 data first
   } vec_t;

   localparam int NVEC = 17;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 32'h0000_0000, 32'h1122_3344, 4'hF, 2'b00, 32'h0, 2'd0},
      '{1'b0, 32'h0000_0000, 32'h0,         4'h0, 2'b00, 32'h1122_3344, 2'd0},
      '{1'b1, 32'h0000_0004, 32'hAABB_CCDD, 4'h5, 2'b00, 32'h0, 2'd1},
      '{1'b0, 32'h0000_0004, 32'h0,         4'h0, 2'b00, 32'h00BB_00DD, 2'd0},
      '{1'b1, 32'h0000_0004, 32'h9988_7766, 4'hA, 2'b00, 32'h0, 2'd2},
      '{1'b0, 32'h0000_0004, 32'h0,         4'h0, 2'b00, 32'h99BB_77DD, 2'd0},
      '{1'b1, 32'h0000_001C, 32'hDEAD_BEEF, 4'hF, 2'b00, 32'h0, 2'd0},
      '{1'b0, 32'h0000_001C, 32'h0,         4'h0, 2'b00, 32'hDEAD_BEEF, 2'd0},
      '{1'b1, 32'h0000_0020, 32'h1234_5678, 4'hF, 2'b10, 32'h0, 2'd1},
      '{1'b1, 32'h0000_0002, 32'hFFFF_FFFF, 4'hF, 2'b10, 32'h0, 2'd2},
      '{1'b0, 32'h0000_0000, 32'h0,         4'h0, 2'b00, 32'h1122_3344, 2'd0},
      '{1'b0, 32'h0000_0020, 32'h0,         4'h0, 2'b10, 32'h0, 2'd0},
      '{1'b0, 32'h0000_001E, 32'h0,         4'h0, 2'b10, 32'h0, 2'd0},
      '{1'b0, 32'h8000_0000, 32'h0,         4'h0, 2'b10, 32'h0, 2'd0},
      '{1'b1, 32'h0000_0010, 32'hCAFE_F00D, 4'h0, 2'b00, 32'h0, 2'd0},
      '{1'b0, 32'h0000_0010, 32'h0,         4'h0, 2'b00, 32'h0, 2'd0},
      '{1'b0, 32'h0000_0008, 32'h0,         4'h0, 2'b00, 32'h0, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] aw_addr = '0, w_data = '0, ar_addr = '0;
   logic [3:0]  w_strb = '0;
   logic        aw_valid = 1'b0, w_valid = 1'b0, b_ready = 1'b0;
   logic        ar_valid = 1'b0, r_ready = 1'b0;
   logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
   logic [1:0]  b_resp, r_resp;
   logic [31:0] r_data;

   int tests = 0;
   int failed = 0;

   always #5 clk = ~clk;

   axil_regslave uut (
      .clk(clk), .rst_n(rst_n),
      .aw_addr(aw_addr), .aw_valid(aw_valid), .aw_ready(aw_ready),
      .w_data(w_data), .w_strb(w_strb), .w_valid(w_valid), .w_ready(w_ready),
      .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
      .ar_addr(ar_addr), .ar_valid(ar_valid), .ar_ready(ar_ready),
      .r_data(r_data), .r_resp(r_resp), .r_valid(r_valid), .r_ready(r_ready)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] addr, input logic [31:0] data,
                           input logic [3:0] strb, input logic [1:0] mode,
                           output logic [1:0] resp);
      logic a_done, d_done, af, df;
      a_done = 1'b0;
      d_done = 1'b0;
      @(negedge clk);
      aw_addr  = addr;
      w_data   = data;
      w_strb   = strb;
      aw_valid = (mode != 2'd2);
      w_valid  = (mode != 2'd1);
      while (!(a_done && d_done)) begin
         af = aw_valid && aw_ready;
         df = w_valid && w_ready;
         @(negedge clk);
         if (af) begin aw_valid = 1'b0; a_done = 1'b1; end
         if (df) begin w_valid = 1'b0; d_done = 1'b1; end
         if (!a_done || !d_done)
            chk("R7", "no response before both halves held", {31'b0, b_valid}, 32'd0);
         if (a_done && !d_done && !w_valid) w_valid = 1'b1;
         if (d_done && !a_done && !aw_valid) aw_valid = 1'b1;
      end
      chk("R7", "response not yet valid in hold cycle", {31'b0, b_valid}, 32'd0);
      @(negedge clk);
      chk("R7", "response valid one cycle after both held", {31'b0, b_valid}, 32'd1);
      resp = b_resp;
      chk("R12", "address ready low while response pending", {31'b0, aw_ready}, 32'd0);
      chk("R12", "data ready low while response pending", {31'b0, w_ready}, 32'd0);
      @(negedge clk);
      chk("R8", "response valid held without ready", {31'b0, b_valid}, 32'd1);
      chk("R8", "response code held without ready", {30'b0, b_resp}, {30'b0, resp});
      b_ready = 1'b1;
      @(negedge clk);
      b_ready = 1'b0;
      chk("R8", "response valid drops after accept", {31'b0, b_valid}, 32'd0);
   endtask

   task automatic do_read(input logic [31:0] addr,
                          output logic [31:0] data, output logic [1:0] resp);
      @(negedge clk);
      ar_addr  = addr;
      ar_valid = 1'b1;
      while (!ar_ready) @(negedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk("R9", "read valid after address accepted", {31'b0, r_valid}, 32'd1);
      data = r_data;
      resp = r_resp;
      chk("R12", "read address ready low while data pending", {31'b0, ar_ready}, 32'd0);
      @(negedge clk);
      chk("R9", "read data held without ready", r_data, data);
      chk("R9", "read response held without ready", {30'b0, r_resp}, {30'b0, resp});
      r_ready = 1'b1;
      @(negedge clk);
      r_ready = 1'b0;
      chk("R9", "read valid drops after accept", {31'b0, r_valid}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      failed++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [1:0]  rs;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle state after reset
      chk("R1", "aw_ready after reset", {31'b0, aw_ready}, 32'd1);
      chk("R1", "w_ready after reset", {31'b0, w_ready}, 32'd1);
      chk("R1", "ar_ready after reset", {31'b0, ar_ready}, 32'd1);
      chk("R1", "b_valid after reset", {31'b0, b_valid}, 32'd0);
      chk("R1", "r_valid after reset", {31'b0, r_valid}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         do_read(32'(i * 4), rd, rs);
         chk("R1", "register zero after reset", rd, 32'd0);
         chk("R11", "legal read OKAY", {30'b0, rs}, 32'd0);
      end

      // table of mixed accesses: R2 R3 R4 R5 R6 R10 R11
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i].wr) begin
            do_write(VEC[i].addr, VEC[i].data, VEC[i].strb, VEC[i].mode, rs);
            chk("R2/R4/R6/R11", $sformatf("table %0d write response", i),
                {30'b0, rs}, {30'b0, VEC[i].resp});
         end else begin
            do_read(VEC[i].addr, rd, rs);
            chk("R2/R5/R11", $sformatf("table %0d read response", i),
                {30'b0, rs}, {30'b0, VEC[i].resp});
            chk("R2/R3/R4/R5/R10", $sformatf("table %0d read data", i),
                rd, VEC[i].rdata);
         end
      end

      // R10: each register holds its own value
      for (int i = 0; i < 8; i++)
         do_write(32'(i * 4), 32'hA500_0000 | 32'(i), 4'hF, 2'(i % 3), rs);
      for (int i = 0; i < 8; i++) begin
         do_read(32'(i * 4), rd, rs);
         chk("R10", "independent register contents", rd, 32'hA500_0000 | 32'(i));
      end

      // R4: illegal write with high address bits leaves the map untouched
      do_write(32'h0000_0100, 32'h0BAD_0BAD, 4'hF, 2'd0, rs);
      chk("R4", "high-bit illegal write SLVERR", {30'b0, rs}, 32'd2);
      do_read(32'h0000_0000, rd, rs);
      chk("R4", "register 0 not aliased by illegal write", rd, 32'hA500_0000);

      // R1: reset in mid-life clears the map
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_read(32'h0000_001C, rd, rs);
      chk("R1", "register cleared by later reset", rd, 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule